// File: doc/BRIEF.md
# Dual Slot-Multiplexed Spreading Code Generator

This block holds two independently configured 13-stage shift-register code generators, one for the transmit direction and one for the receive direction. Both advance once per chip, where a chip is a fixed number of master clocks counted on a master clock enable. A slot timer splits time into alternating transmit and receive halves of equal length. The single code output carries the transmit code while the transmit slot flag is high and the receive code while it is low.

Every time the registered code output takes a new value, the output-enable is dropped for exactly one master clock. An external pull network can then park the line at mid-rail and notch the spectrum. Each generator has its own tap mask, active length (7 to 13 stages) and bandwidth-doubling mode. A force-load pulse captures the configuration. A reset pulse resynchronizes both registers and the slot timing.

Top module: `dual_pn_gen`

## Requirements
- R1: While rst_ni is low and right after it rises, pn_o = 0, pn_oe_o = 0 and tx_slot_o = 1.
- R2: A generator register advances exactly once per CHIP_DIV master clocks, counting only cycles with mclk_en_i high.
- R3: With active length L, the register keeps bits L-1..0, and bits above L-1 are held at 0. Each step shifts it left by one. The new bit 0 is the parity of (state AND taps, over the active bits) XORed with 1 when bits L-2..0 are all zero. The code bit is state bit L-1. With primitive taps, the period is 2^L chips.
- R4: tx_slot_o holds each value for SLOT_CHIPS*CHIP_DIV enabled master clocks. The next value of pn_o is the transmit code bit when tx_slot_o is 1 and the receive code bit when it is 0, both taken from the register state of the previous master clock.
- R5: With out_en_i high, pn_oe_o is 0 in exactly the master clock where pn_o took a new value, and 1 in the other master clocks.
- R6: With out_en_i low at a clock edge, pn_oe_o is 0 after that edge, while pn_o keeps following the code.
- R7: A force_load_i pulse captures taps, length and wide mode for both generators. It sets both registers to 1 and restarts the chip divider and the slot timer, with the transmit slot first. Tap, length or wide inputs changed without a force-load have no effect on pn_o.
- R8: A pn_reset_i pulse sets both registers to 1 and restarts chip and slot timing. It keeps the configuration captured earlier.
- R9: With wide mode set for the generator on air, the code bit is inverted during the second half of each chip, that is, while the divider count is at least CHIP_DIV/2.
- R10: A length value below 7 acts as 7, and a value above 13 acts as 13.
- R11: With mclk_en_i low, the registers, the timing, pn_o and tx_slot_o hold their values.
- R12: A restart (force-load or reset) on the edge that would end a chip and a slot overrides that chip step and slot change. A force-load and a reset together act as a force-load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master clock enable |
| tx_taps_i | input | 13 | Transmit tap mask |
| tx_len_i | input | 4 | Transmit active length |
| tx_wide_i | input | 1 | Transmit bandwidth-doubling mode |
| rx_taps_i | input | 13 | Receive tap mask |
| rx_len_i | input | 4 | Receive active length |
| rx_wide_i | input | 1 | Receive bandwidth-doubling mode |
| force_load_i | input | 1 | Capture configuration and restart |
| pn_reset_i | input | 1 | Resynchronize registers and timing |
| out_en_i | input | 1 | Code output enable |
| pn_o | output | 1 | Multiplexed code bit |
| pn_oe_o | output | 1 | Output drive enable, low for the float gap |
| tx_slot_o | output | 1 | Transmit slot flag (1 = transmit half) |

## Verification
The functions that can land in the same cycle are a restart (force-load or reset) and the chip step that closes the last chip of a slot. A force-load and a reset can also arrive together. The bench walks its slot model until the divider and the chip index are both at their last value, then pulses the reset on that exact edge. Later it pulses force-load and reset together. In both cases the transmit flag must stay high, both codes must restart from the seed, and the configuration captured afterwards must match what a lone force-load would give. Every cycle is compared against a bench model that follows the requirement rules.

// File: rtl/pn_pkg.sv
package pn_pkg;
  localparam int unsigned LFSR_W = 13;
  localparam int unsigned LEN_W  = $clog2(LFSR_W + 1);

  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef struct packed {
    lfsr_t             taps;
    logic [LEN_W-1:0]  len;
    logic              wide;
  } pn_cfg_t;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l,
                                                 input int unsigned lo);
    if (l < LEN_W'(lo))     return LEN_W'(lo);
    if (l > LEN_W'(LFSR_W)) return LEN_W'(LFSR_W);
    return l;
  endfunction
endpackage

// File: rtl/pn_timing.sv
module pn_timing #(
  parameter int unsigned CHIP_DIV   = 16,
  parameter int unsigned SLOT_CHIPS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_en_i,
  input  logic restart_i,
  output logic chip_tick_o,
  output logic second_half_o,
  output logic tx_slot_o
);
  localparam int unsigned DIV_W  = (CHIP_DIV > 2) ? $clog2(CHIP_DIV) : 1;
  localparam int unsigned CHIP_W = (SLOT_CHIPS > 2) ? $clog2(SLOT_CHIPS) : 1;
  localparam logic [DIV_W-1:0]  DIV_MAX  = DIV_W'(CHIP_DIV - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF = DIV_W'(CHIP_DIV / 2);
  localparam logic [CHIP_W-1:0] CHIP_MAX = CHIP_W'(SLOT_CHIPS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [CHIP_W-1:0] chip_q;
  logic              tx_q;

  assign chip_tick_o   = mclk_en_i && !restart_i && (div_q == DIV_MAX);
  assign second_half_o = (div_q >= DIV_HALF);
  assign tx_slot_o     = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      chip_q <= '0;
      tx_q   <= 1'b1;
    end else if (restart_i) begin
      div_q  <= '0;
      chip_q <= '0;
      tx_q   <= 1'b1;
    end else if (mclk_en_i) begin
      if (div_q == DIV_MAX) begin
        div_q <= '0;
        if (chip_q == CHIP_MAX) begin
          chip_q <= '0;
          tx_q   <= ~tx_q;
        end else begin
          chip_q <= chip_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  p_div_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_MAX);
  p_tick_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_tick_o |=> (div_q == '0));
  p_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tx_q && div_q == '0 && chip_q == '0));
  p_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclk_en_i && !restart_i) |=> ($stable(div_q) && $stable(tx_q)));
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr
  import pn_pkg::*;
#(
  parameter int unsigned MIN_LEN = 7
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  logic    seed_i,
  input  logic    step_i,
  input  pn_cfg_t cfg_i,
  output logic    bit_o,
  output logic    wide_o
);
  pn_cfg_t cfg_q;
  lfsr_t   state_q, mask, nxt;
  logic    fb, low_zero, top;

  always_comb begin
    top = 1'b0;
    for (int i = 0; i < LFSR_W; i++) begin
      mask[i] = (LEN_W'(i) < cfg_q.len);
      if (LEN_W'(i + 1) == cfg_q.len) top = state_q[i];
    end
    // zero-detect on the surviving bits inserts the all-zero state: period 2^L
    low_zero = ((state_q & (mask >> 1)) == '0);
    fb       = (^(state_q & cfg_q.taps & mask)) ^ low_zero;
    nxt      = {state_q[LFSR_W-2:0], fb} & mask;
  end

  assign bit_o  = top;
  assign wide_o = cfg_q.wide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{taps: '0, len: LEN_W'(LFSR_W), wide: 1'b0};
      state_q <= lfsr_t'(1);
    end else begin
      if (load_i) begin
        cfg_q.taps <= cfg_i.taps;
        cfg_q.len  <= clamp_len(cfg_i.len, MIN_LEN);
        cfg_q.wide <= cfg_i.wide;
      end
      if (load_i || seed_i) state_q <= lfsr_t'(1);
      else if (step_i)      state_q <= nxt;
    end
  end

  p_len_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q & ~mask) == '0);
  p_seed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || seed_i) |=> (state_q == lfsr_t'(1)));
  p_len_clamp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cfg_q.len >= LEN_W'(MIN_LEN) && cfg_q.len <= LEN_W'(LFSR_W)));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !seed_i) |=> $stable(state_q));
endmodule

// File: rtl/pn_out_stage.sv
module pn_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_en_i,
  input  logic out_en_i,
  input  logic tx_slot_i,
  input  logic second_half_i,
  input  logic tx_bit_i,
  input  logic tx_wide_i,
  input  logic rx_bit_i,
  input  logic rx_wide_i,
  output logic pn_o,
  output logic oe_o
);
  logic pn_q, oe_q, sel;

  assign sel = tx_slot_i ? (tx_bit_i ^ (tx_wide_i & second_half_i))
                         : (rx_bit_i ^ (rx_wide_i & second_half_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pn_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      if (mclk_en_i) pn_q <= sel;
      // float for one master clock whenever the driven value changes
      oe_q <= out_en_i & (mclk_en_i ? (sel == pn_q) : oe_q);
    end
  end

  assign pn_o = pn_q;
  assign oe_o = oe_q;

  p_oe_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pn_q != $past(pn_q)) |-> !oe_q);
  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> !oe_q);
  p_pn_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclk_en_i |=> $stable(pn_q));
endmodule

// File: rtl/dual_pn_gen.sv
module dual_pn_gen
  import pn_pkg::*;
#(
  parameter int unsigned CHIP_DIV   = 16,
  parameter int unsigned SLOT_CHIPS = 64,
  parameter int unsigned MIN_LEN    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_en_i,
  input  logic [LFSR_W-1:0] tx_taps_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic              tx_wide_i,
  input  logic [LFSR_W-1:0] rx_taps_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              rx_wide_i,
  input  logic              force_load_i,
  input  logic              pn_reset_i,
  input  logic              out_en_i,
  output logic              pn_o,
  output logic              pn_oe_o,
  output logic              tx_slot_o
);
  localparam int unsigned N_GEN = 2;  // 0 = transmit, 1 = receive

  logic    restart, chip_tick, second_half, tx_slot;
  pn_cfg_t cfg_in [N_GEN];
  logic    gen_bit [N_GEN];
  logic    gen_wide[N_GEN];

  assign restart   = force_load_i | pn_reset_i;
  assign cfg_in[0] = '{taps: tx_taps_i, len: tx_len_i, wide: tx_wide_i};
  assign cfg_in[1] = '{taps: rx_taps_i, len: rx_len_i, wide: rx_wide_i};

  pn_timing #(.CHIP_DIV(CHIP_DIV), .SLOT_CHIPS(SLOT_CHIPS)) u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mclk_en_i    (mclk_en_i),
    .restart_i    (restart),
    .chip_tick_o  (chip_tick),
    .second_half_o(second_half),
    .tx_slot_o    (tx_slot)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    pn_lfsr #(.MIN_LEN(MIN_LEN)) u_lfsr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(force_load_i),
      .seed_i(pn_reset_i),
      .step_i(chip_tick),
      .cfg_i (cfg_in[g]),
      .bit_o (gen_bit[g]),
      .wide_o(gen_wide[g])
    );
  end

  pn_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mclk_en_i    (mclk_en_i),
    .out_en_i     (out_en_i),
    .tx_slot_i    (tx_slot),
    .second_half_i(second_half),
    .tx_bit_i     (gen_bit[0]),
    .tx_wide_i    (gen_wide[0]),
    .rx_bit_i     (gen_bit[1]),
    .rx_wide_i    (gen_wide[1]),
    .pn_o         (pn_o),
    .oe_o         (pn_oe_o)
  );

  assign tx_slot_o = tx_slot;

  p_slot_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot != $past(tx_slot)) |-> ($past(chip_tick) || $past(restart)));
endmodule

// File: tb/tb_dual_pn_gen.sv
`timescale 1ns/1ps
module tb_dual_pn_gen;
  localparam int D = 4;
  localparam int S = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, mclk_en_i = 1'b1;
  logic [12:0] tx_taps_i = '0, rx_taps_i = '0;
  logic [3:0]  tx_len_i = 4'd13, rx_len_i = 4'd13;
  logic tx_wide_i = 0, rx_wide_i = 0, force_load_i = 0, pn_reset_i = 0, out_en_i = 0;
  logic pn_o, pn_oe_o, tx_slot_o;

  always #2.5 clk_i = ~clk_i;

  dual_pn_gen #(.CHIP_DIV(D), .SLOT_CHIPS(S), .MIN_LEN(7)) dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference state, mirrors requirement rules
  int m_div, m_chip;
  bit m_tx, e_pn, e_oe;
  logic [12:0] m_st[2], m_taps[2];
  int m_len[2];
  bit m_wide[2];

  function automatic int clampl(input int l);
    return (l < 7) ? 7 : ((l > 13) ? 13 : l);
  endfunction

  function automatic logic [12:0] lfsr_next(input logic [12:0] s, input logic [12:0] t, input int l);
    logic [12:0] msk = 13'((1 << l) - 1);
    logic z = ((s & (msk >> 1)) == 0);
    logic f = (^(s & t & msk)) ^ z;
    return ((s << 1) | 13'(f)) & msk;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_div = 0; m_chip = 0; m_tx = 1; e_pn = 0; e_oe = 0;
    for (int g = 0; g < 2; g++) begin
      m_st[g] = 13'd1; m_taps[g] = '0; m_len[g] = 13; m_wide[g] = 0;
    end
  endtask

  task automatic step();
    bit nb, hi;
    @(posedge clk_i);
    hi = (m_div >= D/2);
    nb = m_tx ? (m_st[0][m_len[0]-1] ^ (m_wide[0] & hi))
              : (m_st[1][m_len[1]-1] ^ (m_wide[1] & hi));
    if (mclk_en_i) begin
      e_oe = out_en_i && (nb == e_pn);
      e_pn = nb;
    end else if (!out_en_i) e_oe = 0;
    if (force_load_i || pn_reset_i) begin
      m_div = 0; m_chip = 0; m_tx = 1;
      m_st[0] = 13'd1; m_st[1] = 13'd1;
      if (force_load_i) begin
        m_taps[0] = tx_taps_i; m_len[0] = clampl(tx_len_i); m_wide[0] = tx_wide_i;
        m_taps[1] = rx_taps_i; m_len[1] = clampl(rx_len_i); m_wide[1] = rx_wide_i;
      end
    end else if (mclk_en_i) begin
      if (m_div == D-1) begin
        m_div = 0;
        for (int g = 0; g < 2; g++) m_st[g] = lfsr_next(m_st[g], m_taps[g], m_len[g]);
        if (m_chip == S-1) begin m_chip = 0; m_tx = ~m_tx; end
        else m_chip++;
      end else m_div++;
    end
    @(negedge clk_i);
    chk(pn_o === e_pn, "R2 R3 R4 R9 R10 pn", pn_o, e_pn);
    chk(pn_oe_o === e_oe, "R5 R6 oe", pn_oe_o, e_oe);
    chk(tx_slot_o === m_tx, "R4 R11 slot", tx_slot_o, m_tx);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_load();
    force_load_i = 1; step(); force_load_i = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    chk(pn_o === 0 && pn_oe_o === 0 && tx_slot_o === 1, "R1 reset", {pn_o, pn_oe_o, tx_slot_o}, 3'b001);
    rst_ni = 1;
    run(4);

    // R3 R7: L=7 tx, L=9 rx, primitive taps, full periods
    tx_taps_i = 13'h060; tx_len_i = 7;
    rx_taps_i = 13'h110; rx_len_i = 9;
    out_en_i = 1;
    pulse_load();
    run(2 * 512 * D + 40);

    // R7: tap/length/wide changes without force-load are ignored
    tx_taps_i = 13'h003; tx_len_i = 12; rx_wide_i = 1; tx_wide_i = 1;
    run(300);

    // R8 R12: reset on the edge ending the last chip of a slot
    while (!(m_div == D-1 && m_chip == S-1)) step();
    pn_reset_i = 1; step(); pn_reset_i = 0;
    chk(tx_slot_o === 1, "R12 slot kept", tx_slot_o, 1);
    run(200);

    // R9 R10: wide on both, tx L=13, rx length 3 acts as 7
    tx_taps_i = 13'h100D; tx_len_i = 13; tx_wide_i = 1;
    rx_taps_i = 13'h060;  rx_len_i = 3;  rx_wide_i = 1;
    pulse_load();
    run(1000);

    // R11: sparse master clock enable
    for (int i = 0; i < 600; i++) begin
      mclk_en_i = (i % 3 == 0);
      step();
    end
    mclk_en_i = 1;

    // R6: output enable off
    out_en_i = 0;
    run(200);
    chk(pn_oe_o === 0, "R6 oe held low", pn_oe_o, 0);
    out_en_i = 1;
    run(50);

    // R12: load and reset together, length 15 acts as 13
    while (!(m_div == D-1 && m_chip == S-1)) step();
    tx_taps_i = 13'h100D; tx_len_i = 15; tx_wide_i = 0;
    rx_taps_i = 13'h110;  rx_len_i = 9;  rx_wide_i = 0;
    force_load_i = 1; pn_reset_i = 1; step();
    force_load_i = 0; pn_reset_i = 0;
    chk(tx_slot_o === 1, "R12 load+reset slot", tx_slot_o, 1);

    // R3: full 2^13-chip period of the tx code
    run(8192 * D + 20);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule